// File: doc/BRIEF.md
# Per-Channel Line-Driver Tristate Control Generator

This block produces sixteen active-low drive-enable strobes, one for each of serial output streams 0 to 15. External line drivers sit on those streams, and each strobe switches its driver on or off one timeslot at a time. A shared tick counter runs at the fastest bit rate and restarts on every frame pulse. Each stream sets its own output rate. The stream's channel time and its number of timeslots per frame follow from that rate: 32, 64, 128 or 256 channels of 8 bits in a frame of 2048 ticks.

A per-stream bitmap of 256 entries says which channels are actively driven. For every timeslot, a strobe goes low only when all of these hold:
- the device output-enable pin is high;
- the enable bit in the control word is set;
- the stream is enabled;
- the bitmap entry for that channel is set.

In every other case the strobe stays high, which keeps the driver in high impedance. A companion flag, `data_drive`, tells the serial data outputs whether they may drive at all.

The bitmap is loaded one entry per cycle through a plain write strobe. That port has no back-pressure: every write is accepted in the cycle it is presented. No data stream passes through the block.

Top module: `tzc_tristate_ctl`

## Requirements
- R1: While `rst_n` is low, every `ctl_hz` bit is 1 and `data_drive` is 0, without waiting for a clock edge. Reset clears every bitmap entry to 0, which means high impedance.
- R2: When `oe_pin` is low at a clock edge, every `ctl_hz` bit is 1 and `data_drive` is 0 after that edge.
- R3: When bit 2 of `ctrl_word` is low at a clock edge, every `ctl_hz` bit is 1 and `data_drive` is 0 after that edge. When both enables are high, `data_drive` is 1.
- R4: When both global enables and `strm_en[s]` are high, `ctl_hz[s]` is 0 during timeslot c if bitmap entry (s,c) is 1, and 1 if the entry is 0.
- R5: The rate code `strm_rate[2s+1:2s]` sets the channel time of stream s to 64 >> code ticks. Code 0 gives 32 channels per frame, 1 gives 64, 2 gives 128 and 3 gives 256. The cycle in which `fp_i` is high is tick 0, and the outputs show the slot of tick t after the clock edge of tick t.
- R6: Each stream follows its own rate code, independent of the rate codes of the other streams.
- R7: A stream whose `strm_en` bit is low holds `ctl_hz` high for the whole frame.
- R8: Bitmap entries at or above the channel count of a stream's rate have no effect on that stream's output.
- R9: A frame pulse in the middle of a frame restarts the slot count at tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one cycle per bit at the fastest rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse; the cycle it is high is tick 0 |
| oe_pin | input | 1 | Device output-enable pin |
| ctrl_word | input | 16 | Control word; bit 2 is the strobe enable |
| strm_en | input | 16 | Per-stream output enable |
| strm_rate | input | 32 | Per-stream 2-bit rate code, stream s at bits 2s+1:2s |
| map_we | input | 1 | Bitmap write strobe |
| map_strm | input | 4 | Stream addressed by the write |
| map_chan | input | 8 | Channel addressed by the write |
| map_drive | input | 1 | Value written: 1 = drive, 0 = high impedance |
| ctl_hz | output | 16 | Per-stream strobe: 0 = drive, 1 = high impedance |
| data_drive | output | 1 | 1 when the serial data outputs may drive |

## Verification
A tick counter that is off by even one cycle moves every strobe edge early or late. The fastest stream shows this within 8 ticks, and any stream shows it at its first channel boundary. A wrong shift for a rate code stretches or shrinks the low windows, so a stream with a single driven channel shows the wrong width within one frame. A lost enable or a sticky bitmap entry shows as a strobe that is low when it must be high. This is visible in the very next cycle, because every strobe is one register away from its inputs.

// File: rtl/tzc_pkg.sv
package tzc_pkg;
  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X8 = 2'd3
  } rate_e;

  function automatic int unsigned ceil_log2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/tzc_frame_timer.sv
module tzc_frame_timer #(
  parameter int TICKS  = 2048,
  parameter int TICK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_i,
  output logic [TICK_W-1:0] tick
);
  localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS - 1);

  logic [TICK_W-1:0] cnt_q;

  // The frame pulse cycle is tick 0; otherwise continue the count.
  assign tick = fp_i ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (tick == LAST)  cnt_q <= '0;
    else                    cnt_q <= tick + 1'b1;
  end
endmodule

// File: rtl/tzc_chan_map.sv
module tzc_chan_map #(
  parameter int NSTR   = 16,
  parameter int MAX_CH = 256,
  parameter int SID_W  = 4,
  parameter int CH_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [SID_W-1:0]             wr_strm,
  input  logic [CH_W-1:0]              wr_chan,
  input  logic                         wr_drive,
  output logic [NSTR-1:0][MAX_CH-1:0]  map_q
);
  for (genvar s = 0; s < NSTR; s++) begin : g_row
    logic hit;
    assign hit = we && (wr_strm == SID_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   map_q[s] <= '0;
      else if (hit) map_q[s][wr_chan] <= wr_drive;
    end
  end
endmodule

// File: rtl/tzc_slot_gate.sv
module tzc_slot_gate #(
  parameter int MAX_CH = 256,
  parameter int CH_W   = 8,
  parameter int TICK_W = 11,
  parameter int SH_MIN = 3,
  parameter int NRATES = 4,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick,
  input  logic [RATE_W-1:0] rate,
  input  logic              glb_en,
  input  logic              strm_on,
  input  logic [MAX_CH-1:0] row,
  output logic              hz_q
);
  logic [TICK_W-1:0] slot_full;
  logic [CH_W-1:0]   slot;
  logic              drive;

  // Slower rates have longer channels, so the tick is shifted further.
  assign slot_full = tick >> (SH_MIN + (NRATES - 1) - int'(rate));
  assign slot      = slot_full[CH_W-1:0];
  assign drive     = glb_en && strm_on && row[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hz_q <= 1'b1;
    else        hz_q <= ~drive;
  end
endmodule

// File: rtl/tzc_tristate_ctl.sv
module tzc_tristate_ctl
  import tzc_pkg::*;
#(
  parameter int NSTR    = 16,
  parameter int MAX_CH  = 256,
  parameter int CH_BITS = 8,
  parameter int NRATES  = 4,
  parameter int CW_W    = 16,
  parameter int EN_BIT  = 2,
  localparam int RATE_W = ceil_log2(NRATES),
  localparam int SID_W  = ceil_log2(NSTR),
  localparam int CH_W   = ceil_log2(MAX_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fp_i,
  input  logic                     oe_pin,
  input  logic [CW_W-1:0]          ctrl_word,
  input  logic [NSTR-1:0]          strm_en,
  input  logic [NSTR*RATE_W-1:0]   strm_rate,
  input  logic                     map_we,
  input  logic [SID_W-1:0]         map_strm,
  input  logic [CH_W-1:0]          map_chan,
  input  logic                     map_drive,
  output logic [NSTR-1:0]          ctl_hz,
  output logic                     data_drive
);
  localparam int TICKS  = MAX_CH * CH_BITS;
  localparam int TICK_W = ceil_log2(TICKS);
  localparam int SH_MIN = ceil_log2(CH_BITS);

  logic [TICK_W-1:0]              tick;
  logic [NSTR-1:0][MAX_CH-1:0]    map_q;
  logic                           glb_en;

  assign glb_en = oe_pin && ctrl_word[EN_BIT];

  tzc_frame_timer #(.TICKS(TICKS), .TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .tick(tick)
  );

  tzc_chan_map #(.NSTR(NSTR), .MAX_CH(MAX_CH), .SID_W(SID_W), .CH_W(CH_W)) u_map (
    .clk(clk), .rst_n(rst_n), .we(map_we), .wr_strm(map_strm),
    .wr_chan(map_chan), .wr_drive(map_drive), .map_q(map_q)
  );

  for (genvar s = 0; s < NSTR; s++) begin : g_gate
    tzc_slot_gate #(
      .MAX_CH(MAX_CH), .CH_W(CH_W), .TICK_W(TICK_W),
      .SH_MIN(SH_MIN), .NRATES(NRATES), .RATE_W(RATE_W)
    ) u_gate (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .rate(strm_rate[s*RATE_W +: RATE_W]), .glb_en(glb_en),
      .strm_on(strm_en[s]), .row(map_q[s]), .hz_q(ctl_hz[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_drive <= 1'b0;
    else        data_drive <= glb_en;
  end
endmodule

// File: rtl/tzc_checker.sv
module tzc_checker #(
  parameter int NSTR   = 16,
  parameter int CW_W   = 16,
  parameter int EN_BIT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            oe_pin,
  input logic [CW_W-1:0] ctrl_word,
  input logic [NSTR-1:0] strm_en,
  input logic [NSTR-1:0] ctl_hz,
  input logic            data_drive
);
  // R1: while reset is held, no strobe is allowed to enable a driver
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_hz: assert (&ctl_hz && !data_drive);
  end

  // R1: the two outputs never disagree about a global disable
  a_r1_flag_vs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !data_drive |-> (&ctl_hz));

  // R2
  a_r2_pin_forces_hz: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_pin |=> ((&ctl_hz) && !data_drive));

  // R3
  a_r3_bit_forces_hz: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[EN_BIT] |=> ((&ctl_hz) && !data_drive));

  // R7
  for (genvar s = 0; s < NSTR; s++) begin : g_off
    a_r7_stream_off: assert property (@(posedge clk) disable iff (!rst_n)
      !strm_en[s] |=> ctl_hz[s]);
  end
endmodule

bind tzc_tristate_ctl tzc_checker #(.NSTR(NSTR), .CW_W(CW_W), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .ctrl_word(ctrl_word),
  .strm_en(strm_en), .ctl_hz(ctl_hz), .data_drive(data_drive)
);

// File: tb/tb_tzc_tristate_ctl.sv
module tb_tzc_tristate_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp_i = 1'b0;
  logic        oe_pin = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [15:0] strm_en = '0;
  logic [31:0] strm_rate;
  logic        map_we = 1'b0;
  logic [3:0]  map_strm = '0;
  logic [7:0]  map_chan = '0;
  logic        map_drive = 1'b0;
  logic [15:0] ctl_hz;
  logic        data_drive;

  logic [1:0]  r_rate [16];
  bit          mdl [16][256];
  int          mtick = 2047;
  int          lowcnt [16];
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int s = 0; s < 16; s++) strm_rate[s*2 +: 2] = r_rate[s];
  end

  tzc_tristate_ctl dut (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .oe_pin(oe_pin),
    .ctrl_word(ctrl_word), .strm_en(strm_en), .strm_rate(strm_rate),
    .map_we(map_we), .map_strm(map_strm), .map_chan(map_chan),
    .map_drive(map_drive), .ctl_hz(ctl_hz), .data_drive(data_drive)
  );

  // Model of the tick shown at the outputs after each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mtick <= 2047;
    else if (fp_i) mtick <= 0;
    else           mtick <= (mtick == 2047) ? 0 : mtick + 1;
  end

  function automatic logic exp_hz(int s, int t);
    int sh;
    sh = 6 - int'(r_rate[s]);
    return !(oe_pin && ctrl_word[2] && strm_en[s] && mdl[s][t >> sh]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int s, input int c, input bit v);
    @(negedge clk);
    map_we = 1'b1; map_strm = 4'(s); map_chan = 8'(c); map_drive = v;
    mdl[s][c] = v;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Runs n cycles from a frame pulse and compares every strobe every cycle
  task automatic run_cmp(input int n, input int mid_fp, input string req);
    int mis = 0, fs = -1, fa = 0, fe = 0, dmis = 0;
    for (int s = 0; s < 16; s++) lowcnt[s] = 0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      fp_i = (i == 0) || (i == mid_fp);
      @(posedge clk);
      @(negedge clk);
      fp_i = 1'b0;
      for (int s = 0; s < 16; s++) begin
        if (!ctl_hz[s]) lowcnt[s]++;
        if (ctl_hz[s] !== exp_hz(s, mtick)) begin
          if (mis == 0) begin fs = s; fa = ctl_hz[s]; fe = exp_hz(s, mtick); end
          mis++;
        end
      end
      if (data_drive !== (oe_pin && ctrl_word[2])) dmis++;
    end
    check(mis == 0, req, $sformatf("strobe mismatches (first on stream %0d)", fs), fa, fe);
    check(dmis == 0, req, "data_drive mismatches", dmis, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int s = 0; s < 16; s++) begin
      r_rate[s] = 2'd3;
      for (int c = 0; c < 256; c++) mdl[s][c] = 1'b0;
    end
    oe_pin = 1'b1; ctrl_word = 16'h0004; strm_en = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(ctl_hz == 16'hFFFF && data_drive == 1'b0, "R1", "outputs in reset",
          {ctl_hz, 15'b0, data_drive}, {16'hFFFF, 16'h0});
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_reset_map();
    run_cmp(2048, -1, "R1");
    check(lowcnt[5] == 0, "R1", "map cleared: low cycles", lowcnt[5], 0);
  endtask

  task automatic t_basic();
    for (int c = 0; c < 256; c += 2) wr(0, c, 1'b1);
    r_rate[1] = 2'd0; wr(1, 0, 1'b1);
    r_rate[4] = 2'd2; wr(4, 5, 1'b1); wr(4, 127, 1'b1);
    settle();
    run_cmp(2048, -1, "R4");
    check(lowcnt[0] == 1024, "R5", "rate3 alternating low cycles", lowcnt[0], 1024);
    check(lowcnt[1] == 64, "R5", "rate0 one channel width", lowcnt[1], 64);
    check(lowcnt[4] == 32, "R5", "rate2 two channel width", lowcnt[4], 32);
  endtask

  task automatic t_mixed();
    for (int s = 6; s < 16; s++) begin
      r_rate[s] = 2'(s % 4);
      for (int c = 0; c < (32 << (s % 4)); c++)
        if (((s * 7 + c * 3) % 5) < 2) wr(s, c, 1'b1);
    end
    settle();
    run_cmp(2048, -1, "R6");
  endtask

  task automatic t_pin_low();
    oe_pin = 1'b0; settle();
    run_cmp(600, -1, "R2");
    check(ctl_hz == 16'hFFFF, "R2", "strobes with pin low", ctl_hz, 16'hFFFF);
    oe_pin = 1'b1; settle();
  endtask

  task automatic t_bit_low();
    ctrl_word = 16'hFFFB; settle();
    run_cmp(600, -1, "R3");
    check(data_drive == 1'b0, "R3", "data_drive with bit low", data_drive, 0);
    ctrl_word = 16'h0004; settle();
    check(data_drive == 1'b1, "R3", "data_drive with both enables", data_drive, 1);
  endtask

  task automatic t_disable();
    strm_en = 16'h5F5E; settle();
    run_cmp(2048, -1, "R7");
    check(lowcnt[0] == 0, "R7", "disabled stream low cycles", lowcnt[0], 0);
    strm_en = 16'hFFFF; settle();
  endtask

  task automatic t_beyond();
    r_rate[2] = 2'd0;
    for (int c = 32; c < 40; c++) wr(2, c, 1'b1);
    wr(2, 200, 1'b1);
    settle();
    run_cmp(2048, -1, "R8");
    check(lowcnt[2] == 0, "R8", "entries above 31 on rate0", lowcnt[2], 0);
  endtask

  task automatic t_restart();
    run_cmp(2500, 700, "R9");
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(ctl_hz == 16'hFFFF, "R1", "async reset forces strobes", ctl_hz, 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_map();
    t_basic();
    t_mixed();
    t_pin_low();
    t_bit_low();
    t_disable();
    t_beyond();
    t_restart();
    t_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule